// File: doc/BRIEF.md
# Single-Cell Charge Sequencer

This block is the digital sequencer of a single-cell lithium charger. Comparator decisions about the supply, the battery voltage and the charge current arrive as flags. The flags that mark phase changes are filtered against glitches. The sequencer then steps the charger through conditioning, constant-current, taper and completion. It drives the charger enable and the current selection, plus two active-low status lines and an active-low power-good line.

Three safety limits are measured with one tick-driven counter: the conditioning limit, the constant-current limit and the taper dwell. Every length is a parameter counted in `tick` pulses. When a limit expires the sequencer enters a fault state. It leaves that state by one of two recovery routes, chosen by where the battery stands against the recharge threshold. It also leaves when the active-low enable is released and asserted again.

States: `ST_SLEEP` (no valid supply), `ST_IDLE` (disabled), `ST_PRE` (conditioning), `ST_FAST` (constant current), `ST_TAPER` (regulation with taper dwell running), `ST_DONE`, `ST_FAULT`. Transitions, in priority order:
- lost supply leads to `ST_SLEEP`.
- enable released leads to `ST_IDLE`.
- `ST_SLEEP` goes to `ST_IDLE`. `ST_IDLE` goes to `ST_PRE` or `ST_FAST`.
- `ST_PRE` goes to `ST_FAST` once the battery is above the low threshold, and to `ST_FAULT` when its limit expires.
- `ST_FAST` goes back to `ST_PRE`. It goes to `ST_DONE` on termination, to `ST_FAULT` on its limit, and to `ST_TAPER` at regulation with low current.
- `ST_TAPER` goes to `ST_DONE` on termination or when its dwell expires.
- `ST_DONE` goes to `ST_PRE` or `ST_FAST` on recharge.
- `ST_FAULT` goes to `ST_PRE` or `ST_FAST` after the battery has been seen above the recharge threshold and then drops below it.

Top module: `charge_seq`

## Requirements
- R1: After reset, and whenever the filtered supply flag is low, the block is in sleep. Both status lines are high (OFF), `pg_n` is 1, `chg_on` is 0 and `cur_sel` is 2'b00.
- R2: While `chg_en_n` is 1 the charger is off and both status lines are high. Driving it low again starts a new cycle from a cleared timer, and this also clears a fault.
- R3: With the filtered battery-low flag set, the block conditions the cell with status {stat1_n,stat2_n}=2'b00. Constant current falls back to conditioning if the flag returns.
- R4: If conditioning lasts `PRE_TICKS` charging ticks, the block enters fault. Status becomes 2'b11 and `chg_on` becomes 0.
- R5: Constant current and taper report status 2'b01. If taper is not reached within `CHG_TICKS` charging ticks of constant current, the block enters fault.
- R6: In constant current, `at_reg` together with the filtered low-taper flag starts the taper dwell. After `TAPER_TICKS` ticks the cycle ends. The dwell restarts from zero whenever the filtered low-taper flag drops.
- R7: The filtered termination flag in constant current or taper ends the cycle at once. Status becomes 2'b10 and `chg_on` becomes 0.
- R8: In done, the filtered below-recharge flag starts a new cycle.
- R9: In fault with the battery below the recharge threshold, `fault_cur_en` is 1. Once the battery has been seen above the threshold, `fault_cur_en` is 0. A following drop below the threshold clears the fault and restarts charging.
- R10: `cur_sel` is 2'b00 for the adapter (`usb_src`=0). With `usb_src`=1, `usb_sel` 2'b01 (high) gives 2'b10 (500 mA) and 2'b00 (low) gives 2'b01 (100 mA). `usb_sel` 2'b1x (high impedance) holds `chg_on` and `cur_sel` at 0. `cur_sel` is 2'b00 whenever `chg_on` is 0.
- R11: `over_temp` forces `chg_on` to 0 and freezes the safety counter without changing state. Charging resumes when the flag clears.
- R12: The supply, battery-low, recharge, taper and termination flags take effect only after holding a new level for `DG_TICKS` consecutive ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Timebase pulse for filters and timers |
| supply_ok | input | 1 | Adapter or USB supply valid |
| bat_low | input | 1 | Battery below conditioning threshold |
| bat_below_rch | input | 1 | Battery below recharge threshold |
| at_reg | input | 1 | Battery at regulation voltage |
| i_below_taper | input | 1 | Charge current below taper level |
| i_below_term | input | 1 | Charge current below termination level |
| over_temp | input | 1 | Die over-temperature |
| chg_en_n | input | 1 | Active-low charge enable |
| usb_src | input | 1 | Supply is the USB port |
| usb_sel | input | 2 | Decoded select: 00 low, 01 high, 1x high-Z |
| chg_on | output | 1 | Charger power stage enable |
| cur_sel | output | 2 | 00 set-resistor, 01 100 mA, 10 500 mA |
| fault_cur_en | output | 1 | Small detection current enable |
| stat1_n | output | 1 | Status line 1, 0 = pulled low |
| stat2_n | output | 1 | Status line 2, 0 = pulled low |
| pg_n | output | 1 | Power good, 0 = pulled low |

## Verification
Termination and taper-dwell expiry can both become true in the same cycle in `ST_TAPER`. Either one ends in done, so the priority between them cannot be seen at the ports. The case that matters is a one-tick termination glitch arriving while constant current is running. The bench shows that the glitch leaves status at 2'b01, and that a held termination flag reaches done. A second overlap is over-temperature or a high-impedance USB select while the charge counter runs. It is judged by finding constant current still active long after an unfrozen counter would have expired.

// File: rtl/charge_seq_pkg.sv
package charge_seq_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_IDLE,
        ST_PRE,
        ST_FAST,
        ST_TAPER,
        ST_DONE,
        ST_FAULT
    } chg_state_e;

    localparam int NFLT  = 5;
    localparam int F_SUP = 0;
    localparam int F_LOW = 1;
    localparam int F_RCH = 2;
    localparam int F_TAP = 3;
    localparam int F_TRM = 4;

    localparam logic [1:0] CUR_RSET  = 2'b00;
    localparam logic [1:0] CUR_100MA = 2'b01;
    localparam logic [1:0] CUR_500MA = 2'b10;
endpackage

// File: rtl/charge_seq_deglitch.sv
module charge_seq_deglitch #(
    parameter int NF       = 5,
    parameter int DG_TICKS = 375
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [NF-1:0] raw,
    output logic [NF-1:0] filt
);
    localparam int DGW = (DG_TICKS < 2) ? 1 : $clog2(DG_TICKS);
    localparam logic [DGW-1:0] DG_LAST = DGW'(DG_TICKS - 1);

    for (genvar g = 0; g < NF; g++) begin : g_flt
        logic [DGW-1:0] run;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                filt[g] <= 1'b0;
                run     <= '0;
            end else if (raw[g] == filt[g]) begin
                run <= '0;
            end else if (tick) begin
                if (run == DG_LAST) begin
                    filt[g] <= raw[g];
                    run     <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/charge_seq_timer.sv
module charge_seq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (clr)                   cnt <= '0;
        else if (adv && cnt < limit)    cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= limit);
endmodule

// File: rtl/charge_seq.sv
module charge_seq
    import charge_seq_pkg::*;
#(
    parameter int DG_TICKS    = 375,
    parameter int PRE_TICKS   = 1800000,
    parameter int CHG_TICKS   = 18000000,
    parameter int TAPER_TICKS = 1800000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_ok,
    input  logic       bat_low,
    input  logic       bat_below_rch,
    input  logic       at_reg,
    input  logic       i_below_taper,
    input  logic       i_below_term,
    input  logic       over_temp,
    input  logic       chg_en_n,
    input  logic       usb_src,
    input  logic [1:0] usb_sel,
    output logic       chg_on,
    output logic [1:0] cur_sel,
    output logic       fault_cur_en,
    output logic       stat1_n,
    output logic       stat2_n,
    output logic       pg_n
);
    localparam int MAX_A  = (PRE_TICKS > TAPER_TICKS) ? PRE_TICKS : TAPER_TICKS;
    localparam int MAX_T  = (CHG_TICKS > MAX_A) ? CHG_TICKS : MAX_A;
    localparam int TW     = $clog2(MAX_T + 1);

    logic [NFLT-1:0] raw, filt;
    logic            sup_f, low_f, rch_f, tap_f, trm_f;
    chg_state_e      st, nxt;
    logic            armed, tclr, t_adv, t_exp, allowed, charging;
    logic [TW-1:0]   t_lim;

    assign raw = {i_below_term, i_below_taper, bat_below_rch, bat_low, supply_ok};

    charge_seq_deglitch #(.NF(NFLT), .DG_TICKS(DG_TICKS)) u_dg (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(raw), .filt(filt)
    );

    assign sup_f = filt[F_SUP];
    assign low_f = filt[F_LOW];
    assign rch_f = filt[F_RCH];
    assign tap_f = filt[F_TAP];
    assign trm_f = filt[F_TRM];

    assign allowed  = !over_temp && !(usb_src && usb_sel[1]);
    assign charging = (st == ST_PRE) || (st == ST_FAST) || (st == ST_TAPER);
    assign t_adv    = tick && allowed && charging;

    always_comb begin
        unique case (st)
            ST_PRE:   t_lim = TW'(PRE_TICKS);
            ST_TAPER: t_lim = TW'(TAPER_TICKS);
            default:  t_lim = TW'(CHG_TICKS);
        endcase
    end

    charge_seq_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tclr), .adv(t_adv),
        .limit(t_lim), .expired(t_exp)
    );

    always_comb begin
        nxt = st;
        if (!sup_f) begin
            nxt = ST_SLEEP;
        end else if (chg_en_n) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_SLEEP: nxt = ST_IDLE;
                ST_IDLE:  nxt = low_f ? ST_PRE : ST_FAST;
                ST_PRE: begin
                    if (!low_f)     nxt = ST_FAST;
                    else if (t_exp) nxt = ST_FAULT;
                end
                ST_FAST: begin
                    if (low_f)                nxt = ST_PRE;
                    else if (trm_f)           nxt = ST_DONE;
                    else if (t_exp)           nxt = ST_FAULT;
                    else if (at_reg && tap_f) nxt = ST_TAPER;
                end
                ST_TAPER: begin
                    if (trm_f)      nxt = ST_DONE;
                    else if (tap_f && t_exp) nxt = ST_DONE;
                end
                ST_DONE:  if (rch_f)          nxt = low_f ? ST_PRE : ST_FAST;
                ST_FAULT: if (armed && rch_f) nxt = low_f ? ST_PRE : ST_FAST;
                default:  nxt = ST_SLEEP;
            endcase
        end
    end

    assign tclr = (nxt != st) || ((st == ST_TAPER) && !tap_f);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_SLEEP;
            armed <= 1'b0;
        end else begin
            st    <= nxt;
            armed <= (st == ST_FAULT) && (armed || !rch_f);
        end
    end

    always_comb begin
        chg_on       = charging && allowed;
        fault_cur_en = (st == ST_FAULT) && !armed && rch_f;
        pg_n         = (st == ST_SLEEP);
        cur_sel      = CUR_RSET;
        if (chg_on && usb_src)
            cur_sel = usb_sel[0] ? CUR_500MA : CUR_100MA;
        unique case (st)
            ST_PRE:            {stat1_n, stat2_n} = 2'b00;
            ST_FAST, ST_TAPER: {stat1_n, stat2_n} = 2'b01;
            ST_DONE:           {stat1_n, stat2_n} = 2'b10;
            default:           {stat1_n, stat2_n} = 2'b11;
        endcase
    end
endmodule

// File: rtl/charge_seq_checker.sv
module charge_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       chg_en_n,
    input logic       usb_src,
    input logic       over_temp,
    input logic       chg_on,
    input logic [1:0] cur_sel,
    input logic       fault_cur_en,
    input logic       stat1_n,
    input logic       stat2_n,
    input logic       pg_n
);
    p_sleep_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pg_n |-> (!chg_on && stat1_n && stat2_n));

    p_disable_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_en_n && $past(chg_en_n)) |-> !chg_on);

    p_fault_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cur_en |-> (stat1_n && stat2_n && !chg_on && !pg_n));

    p_usb_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_on && usb_src) |-> (cur_sel != 2'b00));

    p_hot_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |-> !chg_on);

    p_charge_reports_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_on |-> !stat1_n);
endmodule

bind charge_seq charge_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .chg_en_n(chg_en_n), .usb_src(usb_src),
    .over_temp(over_temp), .chg_on(chg_on), .cur_sel(cur_sel),
    .fault_cur_en(fault_cur_en), .stat1_n(stat1_n), .stat2_n(stat2_n),
    .pg_n(pg_n)
);

// File: tb/charge_seq_bench.sv
module charge_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 0, bat_low = 0, bat_below_rch = 0, at_reg = 0;
    logic i_below_taper = 0, i_below_term = 0, over_temp = 0;
    logic chg_en_n = 1, usb_src = 0;
    logic [1:0] usb_sel = 2'b00;
    logic chg_on, fault_cur_en, stat1_n, stat2_n, pg_n;
    logic [1:0] cur_sel;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    charge_seq #(.DG_TICKS(3), .PRE_TICKS(40), .CHG_TICKS(60), .TAPER_TICKS(12)) u_charge_seq (
        .clk(clk), .rst_n(rst_n), .tick(1'b1), .supply_ok(supply_ok),
        .bat_low(bat_low), .bat_below_rch(bat_below_rch), .at_reg(at_reg),
        .i_below_taper(i_below_taper), .i_below_term(i_below_term),
        .over_temp(over_temp), .chg_en_n(chg_en_n), .usb_src(usb_src),
        .usb_sel(usb_sel), .chg_on(chg_on), .cur_sel(cur_sel),
        .fault_cur_en(fault_cur_en), .stat1_n(stat1_n), .stat2_n(stat2_n),
        .pg_n(pg_n)
    );

    // stimulus {sup,low,rch,reg,tap,term,ot,en_n,usb,sel[1:0]} | expect {s1,s2,pg,on,cur[1:0],fc}
    localparam logic [17:0] VEC [17] = '{
        18'b0_0_0_0_0_0_0_1_0_00_1_1_1_0_00_0, // R1 sleep
        18'b1_0_0_0_0_0_0_1_0_00_1_1_0_0_00_0, // R2 idle
        18'b1_1_1_0_0_0_0_0_0_00_0_0_0_1_00_0, // R3 precharge
        18'b1_0_1_0_0_0_0_0_0_00_0_1_0_1_00_0, // R5 fast
        18'b1_0_1_0_0_0_0_0_1_01_0_1_0_1_10_0, // R10 500 mA
        18'b1_0_1_0_0_0_0_0_1_00_0_1_0_1_01_0, // R10 100 mA
        18'b1_0_1_0_0_0_0_0_1_10_0_1_0_0_00_0, // R10 high-Z
        18'b1_0_1_0_0_0_1_0_1_01_0_1_0_0_00_0, // R11 hot
        18'b1_0_0_1_1_0_0_0_0_00_0_1_0_1_00_0, // R6 taper starts
        18'b1_0_0_1_0_0_0_0_0_00_0_1_0_1_00_0, // R6 taper lost
        18'b1_0_0_1_1_0_0_0_0_00_0_1_0_1_00_0, // R6 restarted dwell
        18'b1_0_0_1_1_0_0_0_0_00_1_0_0_0_00_0, // R6 dwell expired
        18'b1_0_1_1_1_0_0_0_0_00_0_1_0_1_00_0, // R8 recharge
        18'b1_0_1_1_1_1_0_0_0_00_1_0_0_0_00_0, // R7 termination
        18'b1_0_1_0_0_0_0_1_0_00_1_1_0_0_00_0, // R2 disabled
        18'b1_0_1_0_0_0_0_0_0_00_0_1_0_1_00_0, // R2 re-enabled
        18'b0_0_1_0_0_0_0_0_0_00_1_1_1_0_00_0  // R1 supply lost
    };
    localparam string VREQ [17] = '{"R1","R2","R3","R5","R10","R10","R10","R11",
        "R6","R6","R6","R6","R8","R7","R2","R2","R1"};

    task automatic chk(input string req, input logic [6:0] exp);
        logic [6:0] act;
        act = {stat1_n, stat2_n, pg_n, chg_on, cur_sel, fault_cur_en};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(2);
        chk("R1", 7'b1_1_1_0_00_0);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1", 7'b1_1_1_0_00_0);
        for (int i = 0; i < 17; i++) begin
            {supply_ok, bat_low, bat_below_rch, at_reg, i_below_taper, i_below_term,
             over_temp, chg_en_n, usb_src, usb_sel} = VEC[i][17:7];
            wait_n(10);
            chk(VREQ[i], VEC[i][6:0]);
        end
        // R4 / R9: conditioning limit with battery below recharge level
        {supply_ok, bat_low, bat_below_rch, chg_en_n} = 4'b1110;
        {at_reg, i_below_taper, i_below_term, over_temp, usb_src} = '0;
        wait_n(20);
        chk("R3", 7'b0_0_0_1_00_0);
        wait_n(35);
        chk("R4", 7'b1_1_0_0_00_1);
        bat_below_rch = 1'b0;
        wait_n(10);
        chk("R9", 7'b1_1_0_0_00_0);
        bat_below_rch = 1'b1;
        wait_n(10);
        chk("R9", 7'b0_0_0_1_00_0);
        // R5: constant-current limit, battery above recharge level
        bat_low = 1'b0;
        wait_n(10);
        chk("R5", 7'b0_1_0_1_00_0);
        bat_below_rch = 1'b0;
        wait_n(40);
        chk("R5", 7'b0_1_0_1_00_0);
        wait_n(30);
        chk("R5", 7'b1_1_0_0_00_0);
        // R2: enable toggle clears the fault
        chg_en_n = 1'b1;
        wait_n(5);
        chk("R2", 7'b1_1_0_0_00_0);
        chg_en_n = 1'b0;
        wait_n(10);
        chk("R2", 7'b0_1_0_1_00_0);
        // R11: over-temperature freezes the counter
        over_temp = 1'b1;
        wait_n(80);
        chk("R11", 7'b0_1_0_0_00_0);
        over_temp = 1'b0;
        wait_n(5);
        chk("R11", 7'b0_1_0_1_00_0);
        // R12: one-tick termination glitch is ignored
        i_below_term = 1'b1;
        wait_n(1);
        i_below_term = 1'b0;
        wait_n(8);
        chk("R12", 7'b0_1_0_1_00_0);
        i_below_term = 1'b1;
        wait_n(8);
        chk("R7", 7'b1_0_0_0_00_0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule